// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus interface controller of a processor whose address and data share one group of lines. The core presents a request that says whether it reads or writes, whether the target is memory or I/O space, and gives the address and, for a write, the data. The controller then runs a bus cycle of four fixed states. The first state places the address on the shared lines and pulses an address-latch strobe so that an external latch holds it. The second state turns the lines around toward the data phase. The third and fourth states carry the data. A slow device can hold the cycle by keeping a ready input low, which repeats a wait state between the third and fourth states.

The controller drives the active-low read and write strobes, a transmit/receive direction output and an active-low enable for the external data transceiver. It also marks each cycle as memory or I/O. Between cycles it can give the whole bus to another master through a hold request and acknowledge handshake. While it has given the bus away, it releases every line it drives through their output enables. It takes the bus back only after the other master has dropped its request and the acknowledge has fallen.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the outputs are at rest: ale=0, rd_n=1, wr_n=1, den_n=1, ad_oe=0, hold_ack=0, ctl_oe=1 and rd_valid=0.
- R2: A request seen while idle (req_accept=1) starts a cycle at the next clock. That first state (T1) lasts exactly one clock, with ale=1, ad_oe=1 and ad_out equal to the request address, while both strobes and den_n stay high.
- R3: mem_io is 1 for a memory cycle and 0 for an I/O cycle, and it holds that value from T1 through T4.
- R4: In a write cycle, from T2 through T4: wr_n=0, den_n=0, dt_rn=1 and ad_oe=1. ad_out carries the write data in its low DW bits, with zeros in the upper AW-DW bits.
- R5: In a read cycle, ad_oe=0 and dt_rn=0 from T2 onward and rd_n=0 from T2 through T4. den_n is 1 in T2 and 0 in T3, in every wait state and in T4.
- R6: The value on ad_in during the last clock of a read cycle's T4 appears on rd_data, with rd_valid=1 for exactly one clock, in the clock that follows T4.
- R7: bus_ready is sampled at the end of T3 and at the end of each wait state. Each sample that is low adds one wait state, and during wait states the active strobe and den_n stay low. T4 follows the first high sample, and both strobes are high in the clock after T4.
- R8: hold_req seen while idle gives hold_ack=1 from the next clock. While hold_ack=1: ad_oe=0, ctl_oe=0 and req_accept=0.
- R9: hold_req raised during a bus cycle does not shorten it. hold_ack stays 0 through T4 and rises in the clock after T4.
- R10: Once hold_req falls, hold_ack falls at the next clock. A waiting request is accepted in that idle clock, and its ale is raised no sooner than the clock after.
- R11: rd_n and wr_n are never low together, and ale is never high in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core requests a bus cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write data |
| req_accept | output | 1 | Request taken at this clock edge |
| rd_data | output | DW | Data returned by a read |
| rd_valid | output | 1 | One-clock pulse, rd_data is valid |
| bus_ready | input | 1 | Addressed device is ready (low inserts waits) |
| hold_req | input | 1 | Another master asks for the bus |
| hold_ack | output | 1 | Bus handed to the other master |
| ad_in | input | DW | Shared lines as seen from outside |
| ad_out | output | AW | Value driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ctl_oe | output | 1 | Drive enable for the strobe and mem_io outputs |
| ale | output | 1 | Address-latch strobe, active high |
| dt_rn | output | 1 | Transceiver direction, 1 = transmit |
| den_n | output | 1 | Transceiver enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| mem_io | output | 1 | 1 = memory cycle, 0 = I/O cycle |

## Verification
The bench builds the block with AW=20 and DW=16. With these widths the four upper address bits must fall to zero once the lines switch from address to write data, and a wrong pad width or a missing mux branch shows up directly on ad_out. The bench gives the same sizes a range of wait counts (zero to three), mixes memory and I/O cycles, and raises hold while idle and in the middle of a cycle. These cases cover the wait loop on both of its exit points and the hold handover from both of its entry states.

// File: rtl/mbs_pkg.sv
// Shared types of the multiplexed bus cycle sequencer.
// Assumes: one bus state per clock; the wait state sits between T3 and T4.
package mbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5,
        ST_HOLD = 3'd6
    } bus_st_e;

    typedef struct packed {
        logic write;
        logic mem;
    } cyc_kind_t;
endpackage

// File: rtl/mbs_fsm.sv
// Bus state sequencer: steps T1..T4, loops in TW while the device is not
// ready, and hands the bus over only between cycles.
// Assumes: hold_req has priority over a new request at a cycle boundary.
module mbs_fsm
    import mbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    bus_ready,
    input  logic    hold_req,
    output bus_st_e st,
    output logic    start
);
    bus_st_e st_nx;
    logic    at_boundary;

    // Cycle boundary: idle, or the last state of a cycle.
    assign at_boundary = (st == ST_IDLE) || (st == ST_T4);
    assign start       = at_boundary && !hold_req && req_valid;

    // Next-state decode.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE, ST_T4: begin
                if (hold_req)       st_nx = ST_HOLD;
                else if (req_valid) st_nx = ST_T1;
                else                st_nx = ST_IDLE;
            end
            ST_T1:   st_nx = ST_T2;
            ST_T2:   st_nx = ST_T3;
            ST_T3, ST_TW: st_nx = bus_ready ? ST_T4 : ST_TW;
            ST_HOLD: st_nx = hold_req ? ST_HOLD : ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end
endmodule

// File: rtl/mbs_req_latch.sv
// Holds the accepted request for the length of its cycle and captures the
// read data at the end of T4.
// Assumes: start is only high at a cycle boundary.
module mbs_req_latch
    import mbs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            req_write,
    input  logic            req_mem,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  bus_st_e         st,
    input  logic [DW-1:0]   ad_in,
    output cyc_kind_t       kind,
    output logic [AW-1:0]   addr_q,
    output logic [DW-1:0]   wdata_q,
    output logic [DW-1:0]   rd_data,
    output logic            rd_valid
);
    logic rd_end;

    assign rd_end = (st == ST_T4) && !kind.write;

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            kind.write <= req_write;
            kind.mem   <= req_mem;
            addr_q     <= req_addr;
            wdata_q    <= req_wdata;
        end
    end

    // Read data capture and one-clock valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_end;
            if (rd_end) rd_data <= ad_in;
        end
    end
endmodule

// File: rtl/mbs_pin_drive.sv
// Decodes the bus state and cycle kind into pin levels and drive enables.
// Assumes: DW <= AW; the data phase uses the low DW lines.
module mbs_pin_drive
    import mbs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  bus_st_e         st,
    input  cyc_kind_t       kind,
    input  logic [AW-1:0]   addr_q,
    input  logic [DW-1:0]   wdata_q,
    output logic [AW-1:0]   ad_out,
    output logic            ad_oe,
    output logic            ctl_oe,
    output logic            ale,
    output logic            dt_rn,
    output logic            den_n,
    output logic            rd_n,
    output logic            wr_n,
    output logic            mem_io,
    output logic            hold_ack
);
    localparam int PAD = AW - DW;

    logic [AW-1:0] data_wide;
    logic          in_cyc;
    logic          data_ph;

    // Widen write data onto the shared lines.
    generate
        if (PAD > 0) begin : g_pad
            assign data_wide = {{PAD{1'b0}}, wdata_q};
        end else begin : g_nopad
            assign data_wide = wdata_q;
        end
    endgenerate

    // Phase flags.
    assign in_cyc  = (st == ST_T1) || (st == ST_T2) || (st == ST_T3) ||
                     (st == ST_TW) || (st == ST_T4);
    assign data_ph = in_cyc && (st != ST_T1);

    // Pin decode.
    always_comb begin
        ale      = (st == ST_T1);
        ad_out   = (st == ST_T1) ? addr_q : data_wide;
        ad_oe    = (st == ST_T1) || (kind.write && data_ph);
        ctl_oe   = (st != ST_HOLD);
        hold_ack = (st == ST_HOLD);
        mem_io   = in_cyc && kind.mem;
        dt_rn    = in_cyc && kind.write;
        rd_n     = !(data_ph && !kind.write);
        wr_n     = !(data_ph && kind.write);
        den_n    = !(data_ph && (kind.write || (st != ST_T2)));
    end
endmodule

// File: rtl/mux_bus_seq.sv
// Top of the multiplexed bus cycle sequencer: state sequencer, request
// holding and pin decode.
// Assumes: external tri-state buffers are driven by ad_oe and ctl_oe.
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            req_mem,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            req_accept,
    output logic [DW-1:0]   rd_data,
    output logic            rd_valid,
    input  logic            bus_ready,
    input  logic            hold_req,
    output logic            hold_ack,
    input  logic [DW-1:0]   ad_in,
    output logic [AW-1:0]   ad_out,
    output logic            ad_oe,
    output logic            ctl_oe,
    output logic            ale,
    output logic            dt_rn,
    output logic            den_n,
    output logic            rd_n,
    output logic            wr_n,
    output logic            mem_io
);
    bus_st_e       st;
    logic          start;
    cyc_kind_t     kind;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    assign req_accept = start;

    mbs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_ready (bus_ready),
        .hold_req  (hold_req),
        .st        (st),
        .start     (start)
    );

    mbs_req_latch #(.AW(AW), .DW(DW)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_write (req_write),
        .req_mem   (req_mem),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .st        (st),
        .ad_in     (ad_in),
        .kind      (kind),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    mbs_pin_drive #(.AW(AW), .DW(DW)) u_pins (
        .st       (st),
        .kind     (kind),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .ctl_oe   (ctl_oe),
        .ale      (ale),
        .dt_rn    (dt_rn),
        .den_n    (den_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .mem_io   (mem_io),
        .hold_ack (hold_ack)
    );
endmodule

// File: rtl/mux_bus_seq_chk.sv
// Port-level checker for the multiplexed bus cycle sequencer.
// Assumes: synchronous active-low reset; all checks are off during reset.
module mux_bus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic ad_oe,
    input logic ctl_oe,
    input logic den_n,
    input logic rd_n,
    input logic wr_n,
    input logic hold_ack,
    input logic req_accept,
    input logic rd_valid
);
    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R11
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R2
    ale_addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && rd_n && wr_n && den_n));

    // R8
    hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!ad_oe && !ctl_oe && !req_accept));

    // R10
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack) |-> !ale);

    // R5
    read_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R6
    rdv_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!rd_n));
endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ale        (ale),
    .ad_oe      (ad_oe),
    .ctl_oe     (ctl_oe),
    .den_n      (den_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .hold_ack   (hold_ack),
    .req_accept (req_accept),
    .rd_valid   (rd_valid)
);

// File: tb/mux_bus_seq_tb.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver task runs bus cycles and pushes expected read
// data; a monitor pops and compares on every rd_valid pulse.
module mux_bus_seq_tb;
    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_accept;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          bus_ready = 1'b1, hold_req = 1'b0;
    logic          hold_ack;
    logic [DW-1:0] ad_in = '0;
    logic [AW-1:0] ad_out;
    logic          ad_oe, ctl_oe, ale, dt_rn, den_n, rd_n, wr_n, mem_io;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    mux_bus_seq #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_mem(req_mem), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_accept(req_accept), .rd_data(rd_data), .rd_valid(rd_valid),
        .bus_ready(bus_ready), .hold_req(hold_req), .hold_ack(hold_ack),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .ctl_oe(ctl_oe),
        .ale(ale), .dt_rn(dt_rn), .den_n(den_n), .rd_n(rd_n), .wr_n(wr_n),
        .mem_io(mem_io)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare returned read data against the scoreboard (R6).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) chk("R6 unexpected rd_valid", 1, 0);
            else chk("R6 rd_data", rd_data, exp_q.pop_front());
        end
    end

    // Driver: one full bus cycle with nw wait states.
    task automatic run_cyc(input logic wr, input logic mem, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input int nw, input logic hold_mid);
        logic sb_n;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_mem = mem; req_addr = a; req_wdata = d;
        #1 chk("R2 accept", req_accept, 1);
        @(negedge clk);                                  // T1
        req_valid = 1'b0;
        chk("R2 ale T1", ale, 1);
        chk("R2 addr T1", ad_out, a);
        chk("R2 oe T1", ad_oe, 1);
        chk("R2 strobes T1", {rd_n, wr_n, den_n}, 3'b111);
        chk("R3 mem_io T1", mem_io, mem);
        if (hold_mid) hold_req = 1'b1;
        @(negedge clk);                                  // T2
        chk("R2 ale one clock", ale, 0);
        chk("R3 mem_io T2", mem_io, mem);
        chk("R9 no ack T2", hold_ack, 0);
        if (wr) begin
            chk("R4 wr_n T2", wr_n, 0);
            chk("R4 data T2", ad_out, {{(AW-DW){1'b0}}, d});
            chk("R4 oe/dir/den T2", {ad_oe, dt_rn, den_n}, 3'b110);
        end else begin
            chk("R5 rd_n T2", rd_n, 0);
            chk("R5 oe/dir/den T2", {ad_oe, dt_rn, den_n}, 3'b001);
        end
        @(negedge clk);                                  // T3
        sb_n = wr ? wr_n : rd_n;
        chk(wr ? "R4 strobe T3" : "R5 strobe T3", {sb_n, den_n}, 2'b00);
        bus_ready = (nw == 0);
        for (int i = 0; i < nw; i++) begin
            @(negedge clk);                              // Tw
            sb_n = wr ? wr_n : rd_n;
            chk("R7 strobe held in wait", {sb_n, den_n, ale}, 3'b000);
            chk("R9 no ack in wait", hold_ack, 0);
            bus_ready = (i + 1 >= nw);
        end
        @(negedge clk);                                  // T4
        sb_n = wr ? wr_n : rd_n;
        chk("R7 strobe T4", {sb_n, den_n}, 2'b00);
        chk("R3 mem_io T4", mem_io, mem);
        chk("R9 no ack T4", hold_ack, 0);
        if (!wr) begin
            ad_in = d;
            exp_q.push_back(d);
        end
        @(negedge clk);                                  // after T4
        bus_ready = 1'b1;
        chk("R7 strobes released", {rd_n, wr_n}, 2'b11);
        if (hold_mid) chk("R9 ack after T4", hold_ack, 1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rest strobes", {ale, rd_n, wr_n, den_n}, 4'b0111);
        chk("R1 rest enables", {ad_oe, hold_ack, ctl_oe, rd_valid}, 4'b0010);

        run_cyc(1'b1, 1'b1, 20'hA5C3E, 16'h1234, 0, 1'b0);
        run_cyc(1'b0, 1'b1, 20'h0F00D, 16'hBEEF, 0, 1'b0);
        run_cyc(1'b1, 1'b0, 20'h00310, 16'hFFFF, 2, 1'b0);
        run_cyc(1'b0, 1'b0, 20'hFFFFF, 16'h8001, 3, 1'b0);
        run_cyc(1'b0, 1'b1, 20'h12345, 16'h0000, 1, 1'b0);

        // Hold from idle (R8) and release (R10).
        @(negedge clk);
        hold_req = 1'b1;
        @(negedge clk);
        chk("R8 ack from idle", hold_ack, 1);
        chk("R8 lines released", {ad_oe, ctl_oe}, 2'b00);
        req_valid = 1'b1; req_write = 1'b1; req_mem = 1'b1;
        req_addr = 20'h55555; req_wdata = 16'hAAAA;
        #1 chk("R8 no accept in hold", req_accept, 0);
        @(negedge clk);
        chk("R8 still held", {hold_ack, ale}, 2'b10);
        hold_req = 1'b0;
        @(negedge clk);
        chk("R10 ack falls", hold_ack, 0);
        chk("R10 no ale at release", ale, 0);
        chk("R10 accept after release", req_accept, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 ale next clock", ale, 1);
        repeat (5) @(negedge clk);

        // Hold raised mid-cycle (R9).
        run_cyc(1'b1, 1'b0, 20'h0ABCD, 16'h5A5A, 1, 1'b1);
        hold_req = 1'b0;
        @(negedge clk);
        chk("R10 ack falls after mid hold", hold_ack, 0);
        run_cyc(1'b0, 1'b1, 20'h00001, 16'hC0DE, 0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R6 scoreboard drained", exp_q.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule